// File: doc/BRIEF.md
# Physical interrupt state tracker

This block keeps the pending and active state of a bank of physical interrupt lines and raises one request towards a CPU. Every line is configured as level-sensitive, edge-sensitive, or message-style. A message-style line is edge-triggered and has no active state. A line is offered to the CPU only while it is enabled and pending and not active, and while no interrupt is in service. An active line is therefore masked until something deactivates it. That can be the end-of-interrupt, a separate deactivate command, or a deactivation strobe from a bank of virtual list registers that has handed the line to a guest.

Each line is a small state machine with four states, named after its {active, pending} bits: `LN_IDLE` (00), `LN_PEND` (01), `LN_ACT` (10) and `LN_PACT` (11). The transitions are:
- Acknowledge moves `LN_PEND` to `LN_ACT`.
- An edge that arrives while active moves `LN_ACT` to `LN_PACT`.
- Deactivate, list-register deactivate and end-of-interrupt in non-split mode move `LN_ACT` to `LN_IDLE` and `LN_PACT` to `LN_PEND`.
- Set-active moves `LN_IDLE` to `LN_ACT` and `LN_PEND` to `LN_PACT`.
- A level line reloads its pending bit from its input on every cycle.

A second state machine holds the in-service flag. It has two states:
- `RUN_IDLE` goes to `RUN_BUSY` on a successful acknowledge.
- `RUN_BUSY` goes back to `RUN_IDLE` on any end-of-interrupt.

Top module: `pint_tracker`

## Requirements
- R1: An active line is never offered to the CPU and never granted by acknowledge, even while it is pending.
- R2: A level line's pending bit is its input as sampled at the previous clock edge. After deactivation the line requests again only if its input is still high.
- R3: An edge line latches a rising edge that arrives while it is active (pending and active together). After deactivation it requests again only if such an edge arrived.
- R4: A set-active command sets a non-message line active without any acknowledge, which masks the line until it is deactivated.
- R5: An end-of-interrupt with `eoi_split`=1 clears only the in-service flag and leaves the line active. A deactivate command then clears the active bit.
- R6: A message line never becomes active. Acknowledge clears its pending bit, and set-active has no effect on it.
- R7: A pulse on `lr_deact_req` clears the active bit of the line selected by `lr_deact_sel`.
- R8: Acknowledge returns, on `ack_id` one cycle later, the lowest-numbered enabled line that is pending and not active. If no line is eligible it returns all ones (7 for 4 lines).
- R9: While the in-service flag is set, `cpu_irq` is held low. With `eoi_split`=0, an end-of-interrupt clears the flag and deactivates the line selected by `eoi_sel` in the same cycle.
- R10: A `cfg_wr` pulse writes the enable bit and the 2-bit trigger field of line `cfg_sel`, with trigger encoding 00 level, 01 edge, 10 message, 11 level. Reset leaves all lines disabled and level-triggered, `ack_id` all ones and `cpu_irq` low. A disabled line is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Physical interrupt inputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Line selected for configuration |
| cfg_enable | input | 1 | Enable bit written |
| cfg_trig | input | 2 | Trigger field written |
| ack_req | input | 1 | Acknowledge request |
| ack_id | output | IDW | Line granted by the last acknowledge, all ones if none |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_sel | input | SELW | Line named by the end-of-interrupt |
| eoi_split | input | 1 | 1: priority drop only, 0: drop and deactivate |
| deact_req | input | 1 | Software deactivate request |
| deact_sel | input | SELW | Line to deactivate |
| lr_deact_req | input | 1 | Deactivate strobe from the list-register bank |
| lr_deact_sel | input | SELW | Physical line for that strobe |
| set_act_req | input | 1 | Set-active request |
| set_act_sel | input | SELW | Line to set active |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the tracker with NUM_LINES=4, which makes SELW 2 and IDW 3, so the all-ones code 7 cannot be confused with a real line. With four lines the bench can run every trigger type on every line, with each deactivation path and the split end-of-interrupt mode. It also drives every non-empty mask of simultaneous edges, and for each mask it checks the full acknowledge order against the set bits in ascending order.

// File: rtl/pint_pkg.sv
package pint_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_EDGE  = 2'b01,
        TRIG_MSG   = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_e;

    // encoding is {active, pending}
    typedef enum logic [1:0] {
        LN_IDLE = 2'b00,
        LN_PEND = 2'b01,
        LN_ACT  = 2'b10,
        LN_PACT = 2'b11
    } ln_state_e;

    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_BUSY = 1'b1
    } run_state_e;

endpackage

// File: rtl/pint_line.sv
module pint_line
    import pint_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e trig,
    input  logic  enable,
    input  logic  sense,
    input  logic  ack_hit,
    input  logic  clr_hit,
    input  logic  set_hit,
    output logic  pending,
    output logic  active,
    output logic  eligible
);

    ln_state_e state_q, state_d;
    logic      sense_q;
    logic      rise;
    logic      pend_nx, act_nx;
    logic      latches_edges;

    assign rise          = sense & ~sense_q;
    assign latches_edges = (trig == TRIG_EDGE) || (trig == TRIG_MSG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            sense_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sense_q <= sense;
        end
    end

    // outputs decoded from the state
    always_comb begin
        unique case (state_q)
            LN_IDLE: begin pending = 1'b0; active = 1'b0; end
            LN_PEND: begin pending = 1'b1; active = 1'b0; end
            LN_ACT:  begin pending = 1'b0; active = 1'b1; end
            LN_PACT: begin pending = 1'b1; active = 1'b1; end
        endcase
    end

    assign eligible = enable & pending & ~active;

    // next state: activation wins over deactivation in the same cycle
    always_comb begin
        if (latches_edges) pend_nx = (pending & ~ack_hit) | rise;
        else               pend_nx = sense;
        if (trig == TRIG_MSG) act_nx = 1'b0;
        else                  act_nx = (active & ~clr_hit) | ack_hit | set_hit;
        state_d = ln_state_e'({act_nx, pend_nx});
    end

    a_r6_msg_never_active: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_MSG) |=> !active);

    a_r4_set_makes_active: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && trig != TRIG_MSG) |=> active);

    a_r7_clear_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !set_hit && !ack_hit) |=> !active);

    a_r3_edge_latched_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_EDGE && active && rise && !clr_hit) |=> (pending && active));

    a_r2_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LEVEL) |=> (pending == $past(sense)));

endmodule

// File: rtl/pint_pick.sv
module pint_pick #(
    parameter int NUM_LINES = 16,
    parameter int IDW       = $clog2(NUM_LINES) + 1
) (
    input  logic [NUM_LINES-1:0] eligible,
    output logic                 valid,
    output logic [IDW-1:0]       idx
);

    // scan downwards so the lowest eligible index is the last one written
    always_comb begin
        valid = 1'b0;
        idx   = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                valid = 1'b1;
                idx   = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/pint_run.sv
module pint_run
    import pint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic drop,
    output logic running
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE: if (take)          state_d = RUN_BUSY;
            RUN_BUSY: if (drop && !take) state_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RUN_IDLE: running = 1'b0;
            RUN_BUSY: running = 1'b1;
        endcase
    end

    a_r9_drop_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !take) |=> !running);

endmodule

// File: rtl/pint_tracker.sv
module pint_tracker
    import pint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int SELW = $clog2(NUM_LINES),
    localparam int IDW  = $clog2(NUM_LINES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 cfg_wr,
    input  logic [SELW-1:0]      cfg_sel,
    input  logic                 cfg_enable,
    input  logic [1:0]           cfg_trig,
    input  logic                 ack_req,
    output logic [IDW-1:0]       ack_id,
    input  logic                 eoi_req,
    input  logic [SELW-1:0]      eoi_sel,
    input  logic                 eoi_split,
    input  logic                 deact_req,
    input  logic [SELW-1:0]      deact_sel,
    input  logic                 lr_deact_req,
    input  logic [SELW-1:0]      lr_deact_sel,
    input  logic                 set_act_req,
    input  logic [SELW-1:0]      set_act_sel,
    output logic                 cpu_irq
);

    logic [NUM_LINES-1:0] en_q;
    trig_e                trig_q [NUM_LINES];
    logic [NUM_LINES-1:0] pend_vec, act_vec, elig_vec;
    logic [NUM_LINES-1:0] ack_hit, clr_hit, set_hit;
    logic                 pick_valid;
    logic [IDW-1:0]       pick_idx;
    logic                 running;
    logic [IDW-1:0]       ack_id_q;

    // configuration store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) trig_q[i] <= TRIG_LEVEL;
        end else if (cfg_wr && (int'(cfg_sel) < NUM_LINES)) begin
            en_q[cfg_sel]   <= cfg_enable;
            trig_q[cfg_sel] <= trig_e'(cfg_trig);
        end
    end

    pint_pick #(.NUM_LINES(NUM_LINES), .IDW(IDW)) pick_i (
        .eligible (elig_vec),
        .valid    (pick_valid),
        .idx      (pick_idx)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign ack_hit[g] = ack_req & pick_valid & (pick_idx == IDW'(g));
            assign clr_hit[g] = (eoi_req & ~eoi_split & (eoi_sel == SELW'(g)))
                              | (deact_req & (deact_sel == SELW'(g)))
                              | (lr_deact_req & (lr_deact_sel == SELW'(g)));
            assign set_hit[g] = set_act_req & (set_act_sel == SELW'(g));

            pint_line line_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig     (trig_q[g]),
                .enable   (en_q[g]),
                .sense    (irq_lines[g]),
                .ack_hit  (ack_hit[g]),
                .clr_hit  (clr_hit[g]),
                .set_hit  (set_hit[g]),
                .pending  (pend_vec[g]),
                .active   (act_vec[g]),
                .eligible (elig_vec[g])
            );
        end
    endgenerate

    pint_run run_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (ack_req & pick_valid),
        .drop    (eoi_req),
        .running (running)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ack_id_q <= '1;
        else if (ack_req) ack_id_q <= pick_valid ? pick_idx : '1;
    end

    assign ack_id  = ack_id_q;
    assign cpu_irq = (|elig_vec) & ~running;

    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

    a_r1_grant_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && pick_valid) |-> !act_vec[pick_idx[SELW-1:0]]);

    a_r9_busy_masks_request: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !cpu_irq);

    a_r8_none_gives_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !pick_valid) |=> (&ack_id));

    a_r1_offered_line_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> |(pend_vec & ~act_vec & en_q));

endmodule

// File: tb/pint_tracker_tb.sv
module pint_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int SELW = 2;
    localparam int IDW  = 3;
    localparam int NONE = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_lines = '0;
    logic            cfg_wr = 1'b0;
    logic [SELW-1:0] cfg_sel = '0;
    logic            cfg_enable = 1'b0;
    logic [1:0]      cfg_trig = '0;
    logic            ack_req = 1'b0;
    logic [IDW-1:0]  ack_id;
    logic            eoi_req = 1'b0;
    logic [SELW-1:0] eoi_sel = '0;
    logic            eoi_split = 1'b0;
    logic            deact_req = 1'b0;
    logic [SELW-1:0] deact_sel = '0;
    logic            lr_deact_req = 1'b0;
    logic [SELW-1:0] lr_deact_sel = '0;
    logic            set_act_req = 1'b0;
    logic [SELW-1:0] set_act_sel = '0;
    logic            cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pint_tracker #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_enable(cfg_enable), .cfg_trig(cfg_trig),
        .ack_req(ack_req), .ack_id(ack_id),
        .eoi_req(eoi_req), .eoi_sel(eoi_sel), .eoi_split(eoi_split),
        .deact_req(deact_req), .deact_sel(deact_sel),
        .lr_deact_req(lr_deact_req), .lr_deact_sel(lr_deact_sel),
        .set_act_req(set_act_req), .set_act_sel(set_act_sel),
        .cpu_irq(cpu_irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int line, input bit en, input int trig);
        cfg_wr = 1'b1; cfg_sel = SELW'(line); cfg_enable = en; cfg_trig = 2'(trig);
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq_lines = m; tick();
        irq_lines = '0; tick();
    endtask

    task automatic ack();
        ack_req = 1'b1; tick(); ack_req = 1'b0;
    endtask

    task automatic eoi(input int line, input bit split);
        eoi_req = 1'b1; eoi_sel = SELW'(line); eoi_split = split;
        tick();
        eoi_req = 1'b0; eoi_split = 1'b0;
    endtask

    task automatic deact(input int line);
        deact_req = 1'b1; deact_sel = SELW'(line); tick(); deact_req = 1'b0;
    endtask

    task automatic lr_deact(input int line);
        lr_deact_req = 1'b1; lr_deact_sel = SELW'(line); tick(); lr_deact_req = 1'b0;
    endtask

    task automatic set_act(input int line);
        set_act_req = 1'b1; set_act_sel = SELW'(line); tick(); set_act_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 reset cpu_irq", int'(cpu_irq), 0);
        chk("R10 reset ack_id", int'(ack_id), NONE);

        // disabled lines are never offered
        irq_lines = '1; tick(); tick();
        chk("R10 disabled no request", int'(cpu_irq), 0);
        ack();
        chk("R10 disabled ack none", int'(ack_id), NONE);
        irq_lines = '0; tick();

        for (int i = 0; i < N; i++) begin
            // level line
            cfg(i, 1'b1, 0);
            irq_lines[i] = 1'b1; tick();
            chk("R2 level request", int'(cpu_irq), 1);
            ack();
            chk("R8 ack level", int'(ack_id), i);
            chk("R9 busy masks", int'(cpu_irq), 0);
            eoi(i, 1'b1);
            chk("R1 active level masked", int'(cpu_irq), 0);
            deact(i);
            chk("R2 resample high", int'(cpu_irq), 1);
            ack();
            chk("R8 ack level again", int'(ack_id), i);
            irq_lines[i] = 1'b0;
            eoi(i, 1'b0);
            chk("R2 resample low", int'(cpu_irq), 0);
            tick();
            chk("R9 eoi deactivates", int'(cpu_irq), 0);

            // edge line
            cfg(i, 1'b1, 1);
            pulse(N'(1 << i));
            chk("R3 edge request", int'(cpu_irq), 1);
            ack();
            chk("R8 ack edge", int'(ack_id), i);
            eoi(i, 1'b1);
            chk("R5 split keeps active", int'(cpu_irq), 0);
            pulse(N'(1 << i));
            chk("R1 pending+active masked", int'(cpu_irq), 0);
            lr_deact(i);
            chk("R7 lr deact re-offers", int'(cpu_irq), 1);
            ack();
            chk("R3 ack latched edge", int'(ack_id), i);
            eoi(i, 1'b0);
            chk("R3 no new edge no request", int'(cpu_irq), 0);

            // message line
            cfg(i, 1'b1, 2);
            pulse(N'(1 << i));
            chk("R6 msg request", int'(cpu_irq), 1);
            ack();
            chk("R6 ack msg", int'(ack_id), i);
            set_act(i);
            eoi(i, 1'b1);
            chk("R6 msg cleared by ack", int'(cpu_irq), 0);
            pulse(N'(1 << i));
            chk("R6 msg not active", int'(cpu_irq), 1);
            ack();
            chk("R6 msg ack after set", int'(ack_id), i);
            eoi(i, 1'b1);
            chk("R6 msg idle", int'(cpu_irq), 0);

            // set-active on a level line
            cfg(i, 1'b1, 0);
            set_act(i);
            irq_lines[i] = 1'b1; tick(); tick();
            chk("R4 set-active masks", int'(cpu_irq), 0);
            ack();
            chk("R4 nothing eligible", int'(ack_id), NONE);
            deact(i);
            chk("R5 deact re-offers", int'(cpu_irq), 1);
            ack();
            chk("R4 ack after deact", int'(ack_id), i);
            irq_lines[i] = 1'b0;
            eoi(i, 1'b0);
            chk("R9 eoi clears", int'(cpu_irq), 0);
            cfg(i, 1'b0, 0);
        end

        // acknowledge order over every non-empty mask of edges
        for (int i = 0; i < N; i++) cfg(i, 1'b1, 1);
        for (int m = 1; m < (1 << N); m++) begin
            pulse(N'(m));
            chk("R8 mask request", int'(cpu_irq), 1);
            for (int j = 0; j < N; j++) begin
                if (m[j]) begin
                    ack();
                    chk("R8 lowest first", int'(ack_id), j);
                end
            end
            ack();
            chk("R8 exhausted", int'(ack_id), NONE);
            for (int j = 0; j < N; j++) begin
                if (m[j]) eoi(j, 1'b0);
            end
            chk("R9 all deactivated", int'(cpu_irq), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule